// File: doc/BRIEF.md
# Ethernet Transmit Framer with Frame Check Sequence

This block turns a frame that sits in a byte-wide transmit FIFO into a serial bitstream, one bit per clock. A one-cycle start pulse from the host arms an internal command bit. While that bit is set, the framer waits until carrier sense has been idle for a full interframe gap. It then raises transmit-enable and sends the preamble and the start-of-frame delimiter. After that it pops the FIFO bytes one at a time and shifts each of them out.

While the bytes go out, a CRC-32 accumulator folds them in. After the byte marked last, the complemented checksum is appended, unless checksum generation is disabled for this frame. When it is disabled, the checksum is expected to be part of the FIFO data already. The command bit stays set for the whole attempt and clears only when a one-cycle done strobe marks the end of it. If the FIFO is empty at a byte boundary before the last byte, the attempt ends early with an underrun strobe.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, txen_o, done_o, underrun_o, fifo_pop_o and cmd_o are all low.
- R2: A start_i pulse sets cmd_o at the next edge. cmd_o stays high through the whole attempt, including the done_o cycle, and is low in the cycle after done_o. start_i pulses while cmd_o is high are ignored, so no second attempt follows.
- R3: Transmission starts only after crs_i has been sampled low at 96 consecutive edges. With the command pending, txen_o rises at the 97th edge after crs_i falls and is still low after the 96th.
- R4: The frame opens with seven 0x55 bytes and then one 0xD5 byte. Each byte is sent least significant bit first, one bit per cycle while txen_o is high.
- R5: FIFO bytes follow the delimiter in FIFO order, each least significant bit first. fifo_pop_o is high for exactly one cycle per byte sent and only while fifo_valid_i is high.
- R6: With crc_dis_i low at start, 32 checksum bits follow the last data byte. The checksum is CRC-32 (polynomial 0x04C11DB7, preset all ones), fed data bits in transmit order, complemented, and sent most significant bit first. For the ASCII bytes "123456789", these 32 bits, with the first bit sent taken as bit 0, form 0xCBF43926.
- R7: With crc_dis_i high at start, the frame ends right after the FIFO byte marked by fifo_last_i, and no checksum bits are added.
- R8: done_o is a single-cycle pulse in the first cycle after the last bit, and txen_o falls in that same cycle.
- R9: If fifo_valid_i is low when the next data byte is needed and the last byte has not been sent, txen_o falls at that boundary. underrun_o and done_o then pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start pulse that arms the command bit |
| crs_i | input | 1 | Carrier sense from the medium |
| crc_dis_i | input | 1 | High: do not append a checksum (sampled at start) |
| fifo_data_i | input | 8 | Byte at the head of the transmit FIFO |
| fifo_valid_i | input | 1 | FIFO head byte is present |
| fifo_last_i | input | 1 | FIFO head byte is the final byte of the frame |
| txd_o | output | 1 | Serial data bit |
| txen_o | output | 1 | Transmit enable |
| fifo_pop_o | output | 1 | Consume the FIFO head byte at this edge |
| cmd_o | output | 1 | Command bit, set by start and cleared at completion |
| done_o | output | 1 | One-cycle end-of-attempt strobe |
| underrun_o | output | 1 | One-cycle strobe, with done_o, when the FIFO ran dry |

## Verification
The assertions assume a FIFO that behaves normally. The head byte and its last flag stay stable until popped, fifo_valid_i does not fall by itself while a byte is waiting, and the host does not pulse start_i while the block is in reset. The bench keeps within this with a FIFO model that moves its head only on fifo_pop_o and is refilled only while the framer is idle. It holds crs_i low during its own transmissions, so the gap counter changes only when a test drives the carrier on purpose.

// File: rtl/etf_pkg.sv
package etf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_FCS,
        S_FIN
    } etf_state_e;

    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;

    // Fold one byte into the running checksum, bit 0 of the byte first.
    function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/etf_defer.sv
module etf_defer #(
    parameter int IFG_BITS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic crs_i,
    output logic gap_ok_o
);
    localparam int CW = $clog2(IFG_BITS + 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || crs_i) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CW'(IFG_BITS)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign gap_ok_o = (idle_cnt == CW'(IFG_BITS));

    // Carrier at an edge always restarts the gap.
    assert_gap_restart_R3: assert property (@(posedge clk) disable iff (rst)
        crs_i |=> !gap_ok_o);

endmodule

// File: rtl/etf_crc32.sv
module etf_crc32 (
    input  logic       clk,
    input  logic       rst,
    input  logic       seed_i,
    input  logic       fold_i,
    input  logic [7:0] byte_i,
    input  logic       shift_i,
    output logic       fcs_bit_o
);
    import etf_pkg::*;

    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst || seed_i) begin
            acc <= CRC_SEED;
        end else if (fold_i) begin
            acc <= crc_fold(acc, byte_i);
        end else if (shift_i) begin
            acc <= {acc[30:0], 1'b1};
        end
    end

    assign fcs_bit_o = ~acc[31];

    // Folding and draining never overlap.
    assert_fold_vs_drain_R6: assert property (@(posedge clk) disable iff (rst)
        !(fold_i && shift_i));

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
    parameter int IFG_BITS  = 96,
    parameter int PRE_BYTES = 7,
    parameter int FCS_BITS  = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       crs_i,
    input  logic       crc_dis_i,
    input  logic [7:0] fifo_data_i,
    input  logic       fifo_valid_i,
    input  logic       fifo_last_i,
    output logic       txd_o,
    output logic       txen_o,
    output logic       fifo_pop_o,
    output logic       cmd_o,
    output logic       done_o,
    output logic       underrun_o
);
    import etf_pkg::*;

    localparam int BCW = $clog2(PRE_BYTES + 1);
    localparam int FCW = $clog2(FCS_BITS);

    etf_state_e     st;
    logic [7:0]     sh;
    logic [2:0]     bitc;
    logic [BCW-1:0] bytec;
    logic [FCW-1:0] fcnt;
    logic           cmd, lastb, nocrc, ur;
    logic           gap_ok, fcs_bit, launch, need, byte_end;

    etf_defer #(.IFG_BITS(IFG_BITS)) u_defer (
        .clk      (clk),
        .rst      (rst),
        .crs_i    (crs_i),
        .gap_ok_o (gap_ok)
    );

    etf_crc32 u_crc (
        .clk       (clk),
        .rst       (rst),
        .seed_i    (launch),
        .fold_i    (fifo_pop_o),
        .byte_i    (fifo_data_i),
        .shift_i   (st == S_FCS),
        .fcs_bit_o (fcs_bit)
    );

    always_comb begin
        launch   = (st == S_IDLE) && cmd && gap_ok && !crs_i;
        byte_end = (bitc == 3'd7);
        need     = byte_end && (((st == S_PRE) && (bytec == BCW'(PRE_BYTES)))
                              || ((st == S_DATA) && !lastb));
    end

    assign fifo_pop_o = need && fifo_valid_i;
    assign txen_o     = (st == S_PRE) || (st == S_DATA) || (st == S_FCS);
    assign txd_o      = (st == S_FCS) ? fcs_bit : sh[0];
    assign cmd_o      = cmd;
    assign done_o     = (st == S_FIN);
    assign underrun_o = (st == S_FIN) && ur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            sh    <= '0;
            bitc  <= '0;
            bytec <= '0;
            fcnt  <= '0;
            cmd   <= 1'b0;
            lastb <= 1'b0;
            nocrc <= 1'b0;
            ur    <= 1'b0;
        end else begin
            if (st == S_FIN)          cmd <= 1'b0;
            else if (!cmd && start_i) cmd <= 1'b1;

            unique case (st)
                S_IDLE: if (launch) begin
                    st    <= S_PRE;
                    sh    <= PRE_BYTE;
                    bitc  <= '0;
                    bytec <= '0;
                    nocrc <= crc_dis_i;
                    ur    <= 1'b0;
                end
                S_PRE, S_DATA: begin
                    bitc <= bitc + 1'b1;
                    sh   <= sh >> 1;
                    if (need) begin
                        if (fifo_valid_i) begin
                            st    <= S_DATA;
                            sh    <= fifo_data_i;
                            lastb <= fifo_last_i;
                        end else begin
                            st <= S_FIN;
                            ur <= 1'b1;
                        end
                    end else if (byte_end && st == S_DATA) begin
                        st   <= nocrc ? S_FIN : S_FCS;
                        fcnt <= '0;
                    end else if (byte_end) begin
                        bytec <= bytec + 1'b1;
                        sh    <= (bytec == BCW'(PRE_BYTES - 1)) ? SFD_BYTE : PRE_BYTE;
                    end
                end
                S_FCS: begin
                    fcnt <= fcnt + 1'b1;
                    if (fcnt == FCW'(FCS_BITS - 1)) st <= S_FIN;
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // The line is driven only while a command is outstanding.
    assert_txen_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        txen_o |-> cmd_o);
    // Completion drops the command bit.
    assert_done_clears_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !cmd_o);
    // A frame only opens once the gap has elapsed.
    assert_open_after_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(txen_o) |-> $past(gap_ok));
    // Pops only happen on the line and only on a present byte.
    assert_pop_legal_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |-> (txen_o && fifo_valid_i));
    // Done is one cycle wide and txen is already low.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_txen_low_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !txen_o);
    // Underrun is reported only as a kind of completion.
    assert_underrun_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> done_o);

endmodule

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, start_i, crs_i, crc_dis_i;
    logic [7:0] fifo_data_i;
    logic       fifo_valid_i, fifo_last_i;
    logic       txd_o, txen_o, fifo_pop_o, cmd_o, done_o, underrun_o;

    eth_tx_framer u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .crs_i(crs_i), .crc_dis_i(crc_dis_i),
        .fifo_data_i(fifo_data_i), .fifo_valid_i(fifo_valid_i), .fifo_last_i(fifo_last_i),
        .txd_o(txd_o), .txen_o(txen_o), .fifo_pop_o(fifo_pop_o), .cmd_o(cmd_o),
        .done_o(done_o), .underrun_o(underrun_o)
    );

    int checks = 0;
    int fails  = 0;

    // FIFO model: head advances only on a pop.
    logic [7:0] fb [64];
    int         fn = 0;
    int         fidx = 0;
    logic       fmark = 1'b1;
    assign fifo_valid_i = (fidx < fn);
    assign fifo_data_i  = (fidx < fn) ? fb[fidx] : 8'h00;
    assign fifo_last_i  = fmark && (fidx == fn - 1);
    always @(posedge clk) if (fifo_pop_o) fidx <= fidx + 1;

    // Line capture and strobe counters.
    bit cap [2048];
    int nb = 0, npop = 0, ndone = 0, nur = 0;
    always @(negedge clk) if (txen_o && nb < 2048) begin cap[nb] = txd_o; nb = nb + 1; end
    always @(posedge clk) begin
        if (fifo_pop_o) npop++;
        if (done_o)     ndone++;
        if (underrun_o) nur++;
    end

    bit ex [2048];
    int nex;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic f = c[31] ^ fb[i][b];
                c = {c[30:0], 1'b0} ^ (f ? 32'h04C1_1DB7 : 32'h0);
            end
        return c;
    endfunction

    task automatic build_exp(input int nbytes, input bit with_fcs);
        logic [31:0] c;
        nex = 0;
        for (int i = 0; i < 8; i++)
            for (int b = 0; b < 8; b++) begin
                ex[nex] = (i == 7) ? 8'hD5 >> b : 8'h55 >> b;
                nex++;
            end
        for (int i = 0; i < nbytes; i++)
            for (int b = 0; b < 8; b++) begin ex[nex] = fb[i][b]; nex++; end
        if (with_fcs) begin
            c = ref_crc(nbytes);
            for (int i = 31; i >= 0; i--) begin ex[nex] = ~c[i]; nex++; end
        end
    endtask

    task automatic compare_line(input string tag);
        int bad = -1;
        chk(nb == nex, {tag, " bit count"}, nb, nex);
        for (int i = 0; i < nex && i < nb; i++) if (bad < 0 && cap[i] != ex[i]) bad = i;
        chk(bad < 0, {tag, " first bad bit index"}, bad, -1);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic clear_counts();
        nb = 0; npop = 0; ndone = 0; nur = 0;
    endtask

    // Waits for done at a negedge and checks that it lasts one cycle (R8).
    task automatic wait_done(input string tag);
        int t = 0;
        while (!done_o && t < 5000) begin @(negedge clk); t++; end
        chk(done_o, {tag, " done seen"}, done_o, 1);
        chk(!txen_o, "R8 txen low with done", txen_o, 0);
        chk(cmd_o, "R2 cmd still set in done cycle", cmd_o, 1);
        @(negedge clk);
        chk(!done_o, "R8 done one cycle", done_o, 0);
        chk(!cmd_o, "R2 cmd cleared after done", cmd_o, 0);
    endtask

    task automatic load(input int n, input bit mark);
        fidx = 0; fn = n; fmark = mark;
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; crs_i = 1'b0; crc_dis_i = 1'b0; fn = 0;
        repeat (3) @(negedge clk);
        chk(!txen_o && !done_o && !underrun_o && !fifo_pop_o && !cmd_o, "R1 reset outputs",
            {txen_o, done_o, underrun_o, fifo_pop_o, cmd_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_o, "R1 cmd idle after reset", cmd_o, 0);
    endtask

    task automatic t_basic_frame();
        fb[0] = 8'hDE; fb[1] = 8'hAD; fb[2] = 8'hBE; fb[3] = 8'hEF; fb[4] = 8'h01;
        load(5, 1'b1); clear_counts();
        crc_dis_i = 1'b0;
        pulse_start();
        chk(cmd_o, "R2 cmd set by start", cmd_o, 1);
        repeat (150) @(negedge clk);
        pulse_start();                       // ignored while armed
        wait_done("R4 R5 R6 basic");
        build_exp(5, 1'b1);
        compare_line("R4 R5 R6 basic frame");
        chk(npop == 5, "R5 one pop per byte", npop, 5);
        repeat (300) @(negedge clk);
        chk(nb == nex && !cmd_o, "R2 no second attempt from ignored start", nb, nex);
    endtask

    task automatic t_check_value();
        logic [31:0] v;
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        load(9, 1'b1); clear_counts();
        pulse_start();
        wait_done("R6 check value");
        v = '0;
        for (int i = 0; i < 32; i++) v[i] = cap[64 + 72 + i];
        chk(v == 32'hCBF43926, "R6 checksum of 123456789", v, 32'hCBF43926);
        chk(nb == 64 + 72 + 32, "R6 frame length", nb, 168);
    endtask

    task automatic t_crc_disabled();
        fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h0F; fb[3] = 8'hF0;
        load(4, 1'b1); clear_counts();
        crc_dis_i = 1'b1;
        pulse_start();
        @(negedge clk) crc_dis_i = 1'b0;     // only the value at start counts
        wait_done("R7 no checksum");
        build_exp(4, 1'b0);
        compare_line("R7 no checksum frame");
        chk(npop == 4, "R7 pops", npop, 4);
    endtask

    task automatic t_defer();
        fb[0] = 8'h77; load(1, 1'b1); clear_counts();
        @(negedge clk) crs_i = 1'b1;
        pulse_start();
        repeat (40) @(negedge clk);
        chk(!txen_o && nb == 0, "R3 no transmit under carrier", txen_o, 0);
        crs_i = 1'b0;
        repeat (96) @(negedge clk);
        chk(!txen_o, "R3 still deferring after 96 idle edges", txen_o, 0);
        @(negedge clk);
        chk(txen_o, "R3 opens at 97th edge", txen_o, 1);
        wait_done("R3 deferred frame");
        build_exp(1, 1'b1);
        compare_line("R3 deferred frame");
    endtask

    task automatic t_underrun();
        fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
        load(3, 1'b0); clear_counts();
        pulse_start();
        wait_done("R9 underrun");
        build_exp(3, 1'b0);
        compare_line("R9 truncated frame");
        chk(nur == 1 && ndone == 1, "R9 underrun with done", nur, 1);
        chk(npop == 3, "R9 pops before underrun", npop, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_frame();
        t_check_value();
        t_crc_disabled();
        t_defer();
        t_underrun();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule